// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers seven interrupt causes into one 8-bit status register whose flags are sticky. Four comparator levels and an 8-bit input port arrive without a clock relation, so each passes through a synchronizer, and a flag is raised when its level changes in either direction. The active-low external request pin raises its flag on a falling edge. A single-cycle timer overflow pulse, already in this clock domain, raises a flag directly.

Software reads the flags and can only clear them. A flag-write clears every bit written as 0 and leaves every bit written as 1 unchanged. A separate mask register selects which flags drive the single interrupt request output. After reset, change detection stays disarmed until the synchronizer chain holds real input levels. Whatever static levels the inputs hold at reset therefore raise no flag.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register, the mask register and `irqReq` are all zero.
- R2: A level change of `cmpIn[i]`, rising or falling, sets flag bit 4+i (comparator 0 maps to bit 4, comparator 3 to bit 7).
- R3: Flag bit 3 always reads 0, even after a write of all ones or when every source fires at once.
- R4: A falling edge on `extIntN` sets flag bit 2. A rising edge sets nothing.
- R5: A change on any one or more pins of `portIn` sets flag bit 1.
- R6: `tmrOvf` high at a rising clock edge sets flag bit 0 at that edge.
- R7: A set flag stays set until a flag-write clears it. No flag rises without a source event.
- R8: A flag-write (`flagWrEn`) clears each flag whose bit in `flagWrData` is 0 and leaves the others unchanged. A write never sets a flag.
- R9: When a source sets a flag at the same edge as a write clears it, the flag ends set.
- R10: `maskWrEn` loads `maskWrData` into `mask`. `irqReq` is high exactly when some flag other than bit 3 is set with its mask bit set.
- R11: A change on an asynchronous input, applied between two edges, becomes visible in `flags` after the third following rising edge and not after the second.
- R12: Static input levels held across reset, including `extIntN` low, set no flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpIn | input | 4 | Comparator output levels, asynchronous |
| extIntN | input | 1 | Active-low external interrupt pin, asynchronous |
| portIn | input | PORT_W | Input port levels, asynchronous |
| tmrOvf | input | 1 | Timer overflow pulse, synchronous |
| flagWrEn | input | 1 | Flag clear-write strobe |
| flagWrData | input | 8 | Flag write data (0 clears, 1 keeps) |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 8 | New mask value |
| flags | output | 8 | Interrupt flag register |
| mask | output | 8 | Interrupt mask register |
| irqReq | output | 1 | Combined interrupt request |

## Verification
A hardware set and a software clear can land on the same flag in the same cycle. This is the race that decides whether an interrupt is lost. The bench provokes it twice. First, a timer pulse is driven in the cycle of an all-zero flag write. Second, a comparator change is timed so that its synchronized detection meets a write at the third edge after the change. In both cases only the bit being set must survive, while other flags cleared by the same write must fall.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int CMP_N    = 4;
  localparam int TMR_BIT  = 0;
  localparam int PORT_BIT = 1;
  localparam int EXT_BIT  = 2;
  localparam int RSVD_BIT = 3;
  localparam int CMP_LSB  = 4;
  localparam logic [REG_W-1:0] LIVE_BITS = ~(REG_W'(1) << RSVD_BIT);

  typedef struct packed {
    logic [REG_W-1:0] setBits;
    logic             clrEn;
    logic [REG_W-1:0] keepBits;
    logic             maskLd;
    logic [REG_W-1:0] maskVal;
  } irqStrobes_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) r <= RST_VAL;
          else       r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) r <= RST_VAL;
          else       r <= g_stage[s-1].r;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMP_N-1:0]  cmpIn,
  input  logic              extIntN,
  input  logic [PORT_W-1:0] portIn,
  input  logic              tmrOvf,
  input  logic              flagWrEn,
  input  logic [REG_W-1:0]  flagWrData,
  input  logic              maskWrEn,
  input  logic [REG_W-1:0]  maskWrData,
  output irqStrobes_t       strobes
);
  localparam int IN_W    = CMP_N + 1 + PORT_W;
  localparam int EXT_IDX = CMP_N;
  localparam int ARM_N   = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_N + 1);
  localparam logic [IN_W-1:0] SYNC_RST = {{PORT_W{1'b0}}, 1'b1, {CMP_N{1'b0}}};

  logic [IN_W-1:0] rawIn, syncIn, prevIn, chg;
  logic [ARM_W-1:0] armCnt;
  logic armed;
  logic extFall, portChg;

  assign rawIn = {portIn, extIntN, cmpIn};

  irq_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) uSync (
    .clk(clk), .rstN(rstN), .d(rawIn), .q(syncIn)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevIn <= SYNC_RST;
    else       prevIn <= syncIn;

  // detection stays off until the chain and the previous-value stage hold live levels
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       armCnt <= '0;
    else if (!armed) armCnt <= armCnt + ARM_W'(1);

  assign armed   = (armCnt == ARM_W'(ARM_N));
  assign chg     = syncIn ^ prevIn;
  assign extFall = prevIn[EXT_IDX] & ~syncIn[EXT_IDX];
  assign portChg = |chg[IN_W-1:EXT_IDX+1];

  always_comb begin
    strobes = '0;
    if (armed) begin
      strobes.setBits[CMP_LSB +: CMP_N] = chg[CMP_N-1:0];
      strobes.setBits[EXT_BIT]          = extFall;
      strobes.setBits[PORT_BIT]         = portChg;
    end
    strobes.setBits[TMR_BIT] = tmrOvf;
    strobes.clrEn    = flagWrEn;
    strobes.keepBits = flagWrData;
    strobes.maskLd   = maskWrEn;
    strobes.maskVal  = maskWrData;
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] mask,
  output logic             irqReq
);
  logic [REG_W-1:0] kept, flagsNext;

  assign kept      = strobes.clrEn ? (flags & strobes.keepBits) : flags;
  assign flagsNext = (kept | strobes.setBits) & LIVE_BITS;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               mask <= '0;
    else if (strobes.maskLd) mask <= strobes.maskVal;

  assign irqReq = |(flags & mask & LIVE_BITS);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cmpIn,
  input  logic              extIntN,
  input  logic [PORT_W-1:0] portIn,
  input  logic              tmrOvf,
  input  logic              flagWrEn,
  input  logic [7:0]        flagWrData,
  input  logic              maskWrEn,
  input  logic [7:0]        maskWrData,
  output logic [7:0]        flags,
  output logic [7:0]        mask,
  output logic              irqReq
);
  irqStrobes_t strobes;
  logic [REG_W-1:0] setVec;

  irq_event_ctrl #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .extIntN(extIntN), .portIn(portIn),
    .tmrOvf(tmrOvf), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .strobes(strobes)
  );

  irq_flag_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .flags(flags), .mask(mask), .irqReq(irqReq)
  );

  assign setVec = strobes.setBits;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tmrOvf,
  input logic       flagWrEn,
  input logic [7:0] flagWrData,
  input logic       maskWrEn,
  input logic [7:0] maskWrData,
  input logic [7:0] setVec,
  input logic [7:0] flags,
  input logic [7:0] mask,
  input logic       irqReq
);
  // R3
  bit3_zero_chk: assert property (@(posedge clk) disable iff (!rstN) flags[3] == 1'b0);

  // R6
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rstN) tmrOvf |=> flags[0]);

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (flags & ~$past(flags) & ~$past(setVec)) == 8'h00);

  // R8
  clear_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (flags & ~$past(flagWrData) & ~$past(setVec)) == 8'h00);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(setVec) & ~flags & 8'hF7) == 8'h00);

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> mask == $past(maskWrData));

  // R10
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == |(flags & mask & 8'hF7));
endmodule

bind irq_flag_ctrl irq_flag_chk uChk (
  .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .flagWrEn(flagWrEn),
  .flagWrData(flagWrData), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
  .setVec(setVec), .flags(flags), .mask(mask), .irqReq(irqReq)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic [3:0] cmpIn = 4'b1010;
  logic extIntN = 1'b0;
  logic [7:0] portIn = 8'hA5;
  logic tmrOvf = 1'b0;
  logic flagWrEn = 1'b0;
  logic [7:0] flagWrData = 8'h00;
  logic maskWrEn = 1'b0;
  logic [7:0] maskWrData = 8'h00;
  logic [7:0] flags, mask;
  logic irqReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  irq_flag_ctrl dut (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .extIntN(extIntN), .portIn(portIn),
    .tmrOvf(tmrOvf), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .flags(flags), .mask(mask), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeFlags(input logic [7:0] d);
    flagWrEn = 1'b1; flagWrData = d;
    @(posedge clk); @(negedge clk);
    flagWrEn = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] d);
    maskWrEn = 1'b1; maskWrData = d;
    @(posedge clk); @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  task automatic tReset();
    cycles(2);
    rstN = 1'b1;
    check("R1 flags after reset", flags, 8'h00);
    check("R1 mask after reset", mask, 8'h00);
    check("R1 irqReq after reset", {7'h0, irqReq}, 8'h00);
    cycles(6);
    check("R12 no flag from static levels", flags, 8'h00);
    extIntN = 1'b1;
    cycles(4);
    check("R4 rising edge sets nothing", flags, 8'h00);
  endtask

  task automatic tCmp();
    for (int i = 0; i < 4; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        cmpIn[i] = ~cmpIn[i];
        cycles(2);
        check("R11 not visible after second edge", flags, 8'h00);
        cycles(1);
        check("R2 comparator change flag", flags, 8'h10 << i);
        writeFlags(8'h00);
        check("R8 clear comparator flag", flags, 8'h00);
      end
    end
  endtask

  task automatic tExt();
    extIntN = 1'b0;
    cycles(3);
    check("R4 falling edge sets bit 2", flags, 8'h04);
    writeFlags(8'hFB);
    check("R8 clear bit 2", flags, 8'h00);
    extIntN = 1'b1;
    cycles(4);
    check("R4 rising edge ignored", flags, 8'h00);
  endtask

  task automatic tPort();
    portIn[5] = ~portIn[5];
    cycles(3);
    check("R5 single pin change", flags, 8'h02);
    cycles(5);
    check("R7 port flag sticky", flags, 8'h02);
    writeFlags(8'h00);
    portIn = portIn ^ 8'h81;
    cycles(3);
    check("R5 two pin change", flags, 8'h02);
    writeFlags(8'h00);
    check("R8 clear port flag", flags, 8'h00);
  endtask

  task automatic tTimer();
    tmrOvf = 1'b1;
    @(posedge clk); @(negedge clk);
    tmrOvf = 1'b0;
    check("R6 timer sets bit 0", flags, 8'h01);
    cycles(5);
    check("R7 timer flag sticky", flags, 8'h01);
    writeFlags(8'h00);
  endtask

  task automatic tClear();
    cmpIn[0] = ~cmpIn[0];
    portIn[2] = ~portIn[2];
    tmrOvf = 1'b1;
    @(posedge clk); @(negedge clk);
    tmrOvf = 1'b0;
    cycles(3);
    check("R2 R5 R6 combined flags", flags, 8'h13);
    writeFlags(8'hFE);
    check("R8 partial clear", flags, 8'h12);
    writeFlags(8'hFF);
    check("R8 write of ones sets nothing", flags, 8'h12);
    writeFlags(8'h00);
    check("R8 full clear", flags, 8'h00);
  endtask

  task automatic tSetWins();
    portIn[0] = ~portIn[0];
    cycles(3);
    tmrOvf = 1'b1; flagWrEn = 1'b1; flagWrData = 8'h00;
    @(posedge clk); @(negedge clk);
    tmrOvf = 1'b0; flagWrEn = 1'b0;
    check("R9 timer set beats clear", flags, 8'h01);
    cmpIn[3] = ~cmpIn[3];
    cycles(2);
    writeFlags(8'h00);
    check("R9 comparator set beats clear", flags, 8'h80);
    writeFlags(8'h00);
  endtask

  task automatic tMask();
    cmpIn[3] = ~cmpIn[3];
    tmrOvf = 1'b1;
    @(posedge clk); @(negedge clk);
    tmrOvf = 1'b0;
    cycles(3);
    check("R10 flags for mask test", flags, 8'h81);
    check("R10 no request with mask zero", {7'h0, irqReq}, 8'h00);
    writeMask(8'h01);
    check("R10 mask readback", mask, 8'h01);
    check("R10 request via bit 0", {7'h0, irqReq}, 8'h01);
    writeMask(8'h7E);
    check("R10 disjoint mask", {7'h0, irqReq}, 8'h00);
    writeMask(8'h80);
    check("R10 request via bit 7", {7'h0, irqReq}, 8'h01);
    writeFlags(8'h00);
    writeMask(8'hFF);
    check("R10 no flags no request", {7'h0, irqReq}, 8'h00);
  endtask

  task automatic tBit3();
    cmpIn = ~cmpIn;
    extIntN = 1'b0;
    portIn = ~portIn;
    tmrOvf = 1'b1;
    @(posedge clk); @(negedge clk);
    tmrOvf = 1'b0;
    cycles(3);
    check("R3 all sources, bit 3 zero", flags, 8'hF7);
    writeFlags(8'hFF);
    check("R3 after all-ones write", flags, 8'hF7);
    extIntN = 1'b1;
    writeFlags(8'h00);
    cycles(4);
    check("R4 R8 cleared and quiet", flags, 8'h00);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tCmp();
    tExt();
    tPort();
    tTimer();
    tClear();
    tSetWins();
    tMask();
    tBit3();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule